// File: doc/BRIEF.md
# Floppy Drive Control and Status Register

This block is a byte-wide I/O register that sits next to a floppy disk controller. A write to its port address splits the data byte into separate drive-control outputs: a two-bit drive number, the drive size (5.25-inch or 8-inch), head select, double density and auto-wait enable. A read from the same port returns a status byte built from the controller's data-request and interrupt-request lines.

A periodic `tick` input runs two timers. While head select is high, a motor timer counts ticks and drops head select once a fixed number of ticks (128 by default) has passed since head select was last written. Every tick, whatever the head state, also advances a free-running real-time counter and sets a timer interrupt-pending flag. That flag stays set until an acknowledge strobe clears it.

Top module: `fdc_ctrl_reg`

## Requirements
- R1: A write takes effect only when `io_wr` is high and `io_addr` equals `PORT_ADDR` (default 0x14). A write to any other address leaves every control output unchanged.
- R2: On an accepted write, `drive_sel` takes data bits 1:0 on the next clock edge.
- R3: On an accepted write, `mini_drive` takes data bit 4 (1 = 5.25-inch drive, 0 = 8-inch drive).
- R4: On an accepted write, `dbl_dens` takes data bit 3 and `auto_wait` takes data bit 7. Data bits 5 and 6 have no effect.
- R5: On an accepted write, `head_sel` takes data bit 2 and the motor timer restarts from zero. A write wins over a tick in the same cycle.
- R6: Each tick while `head_sel` is 1 advances the motor timer. On the `TMO_TICKS`-th such tick (default 128), `head_sel` goes to 0. Ticks while `head_sel` is 0 do not advance the timer.
- R7: Every tick adds one to `rtc_count`, and the count wraps from 255 to 0.
- R8: Every tick sets `tmr_pend`. It stays set until a `pend_ack` strobe arrives in a cycle with no tick. If a tick and an acknowledge come in the same cycle, the flag stays set.
- R9: While `io_rd` is high and `io_addr` equals `PORT_ADDR`, `io_rdata` is combinational: 0xFF if DRQ is high and INTRQ low, 0x7F if both are high, and 0x00 if DRQ is low. At all other times `io_rdata` is 0x00.
- R10: A synchronous active-low reset clears all control outputs, the motor timer, `rtc_count` and `tmr_pend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (status byte when addressed) |
| fdc_drq | input | 1 | Controller data request |
| fdc_intrq | input | 1 | Controller interrupt request |
| tick | input | 1 | Periodic timer tick, one cycle wide |
| pend_ack | input | 1 | Clears the timer interrupt-pending flag |
| drive_sel | output | 2 | Selected drive number |
| mini_drive | output | 1 | 1 = 5.25-inch drive, 0 = 8-inch drive |
| head_sel | output | 1 | Head select / head loaded |
| dbl_dens | output | 1 | Double density enable |
| auto_wait | output | 1 | Auto-wait enable |
| rtc_count | output | RTC_W | Real-time tick counter |
| tmr_pend | output | 1 | Timer interrupt pending |

## Verification
The bench targets the motor timeout exactly at its edge. It writes head select, lets 127 ticks pass, and checks the head is still selected; the 128th tick must drop it. A timer that ends one tick early or late fails that check, and so does a timer that keeps counting while the head is off. A second head-select write partway through the interval must restart the full count; a design that fails to clear the counter drops the head too early. The bench also drives every DRQ/INTRQ combination to catch a status byte whose masking is inverted or applied in the wrong order. It runs past 255 ticks to check the counter wraps. It raises tick and acknowledge together to check that the pending flag survives. It writes to an address off by one to check the address decode.

// File: rtl/fdcr_pkg.sv
// Package: bit positions of the control byte and the decoded configuration type.
// Assumes an 8-bit I/O data path.
package fdcr_pkg;
    localparam int DATA_W    = 8;
    localparam int DRV_LSB   = 0;
    localparam int DRV_W     = 2;
    localparam int HEAD_BIT  = 2;
    localparam int DENS_BIT  = 3;
    localparam int MINI_BIT  = 4;
    localparam int AWAIT_BIT = 7;

    typedef struct packed {
        logic             auto_wait;
        logic             mini;
        logic             dbl_dens;
        logic [DRV_W-1:0] drive;
    } fdcr_cfg_t;
endpackage

// File: rtl/fdcr_cfg_reg.sv
// Holds the static drive-configuration fields that an accepted write loads.
// Assumes wr_hit is already qualified by the address decode.
module fdcr_cfg_reg
    import fdcr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_hit,
    input  fdcr_cfg_t cfg_in,
    output fdcr_cfg_t cfg_q
);
    // Load the configuration on an accepted write; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_hit) cfg_q <= cfg_in;
    end

    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(cfg_q));
    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> cfg_q == $past(cfg_in));
endmodule

// File: rtl/fdcr_motor_tmr.sv
// Head-select register with a motor timer: drops head select after TMO_TICKS ticks.
// Assumes tick is one cycle wide; a write restarts the interval and wins over a tick.
module fdcr_motor_tmr #(
    parameter int TMO_TICKS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic head_wr,
    input  logic tick,
    output logic head_sel
);
    localparam int CW = $clog2(TMO_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO_TICKS - 1);

    logic [CW-1:0] cnt;

    // Write loads head select and restarts the timer; ticks count while the head is selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_sel <= 1'b0;
            cnt      <= '0;
        end else if (wr_hit) begin
            head_sel <= head_wr;
            cnt      <= '0;
        end else if (tick && head_sel) begin
            if (cnt == LAST) begin
                head_sel <= 1'b0;
                cnt      <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R6
    head_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(head_sel) |-> $past(tick || wr_hit));
    // R5
    head_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> head_sel == $past(head_wr));
    // R6
    idle_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!head_sel && !wr_hit) |=> cnt == '0);
endmodule

// File: rtl/fdcr_tick_unit.sv
// Real-time tick counter and timer interrupt-pending flag.
// Assumes tick and ack are single-cycle strobes; a tick wins over ack.
module fdcr_tick_unit #(
    parameter int RTC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ack,
    output logic [RTC_W-1:0] rtc,
    output logic             pend
);
    // Advance the free-running counter on every tick (wraps naturally).
    always_ff @(posedge clk) begin
        if (!rst_n)    rtc <= '0;
        else if (tick) rtc <= rtc + 1'b1;
    end

    // Set the pending flag on a tick; clear it on an acknowledge without a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend <= 1'b0;
        else if (tick)  pend <= 1'b1;
        else if (ack)   pend <= 1'b0;
    end

    // R7
    rtc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> rtc == RTC_W'($past(rtc) + 1'b1));
    // R7
    rtc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(rtc));
    // R8
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pend);
    // R8
    pend_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(tick));
endmodule

// File: rtl/fdc_ctrl_reg.sv
// Floppy drive control/status register: decodes the port, splits the write byte
// into drive controls, forms the status read byte, and hosts the tick timers.
// Assumes single-cycle io_wr strobes and a combinational read path.
module fdc_ctrl_reg
    import fdcr_pkg::*;
#(
    parameter logic [7:0] PORT_ADDR = 8'h14,
    parameter int         TMO_TICKS = 128,
    parameter int         RTC_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              fdc_drq,
    input  logic              fdc_intrq,
    input  logic              tick,
    input  logic              pend_ack,
    output logic [1:0]        drive_sel,
    output logic              mini_drive,
    output logic              head_sel,
    output logic              dbl_dens,
    output logic              auto_wait,
    output logic [RTC_W-1:0]  rtc_count,
    output logic              tmr_pend
);
    localparam logic [DATA_W-1:0] TOP_MASK = DATA_W'(1) << (DATA_W - 1);

    logic      addr_hit;
    logic      wr_hit;
    fdcr_cfg_t cfg_in;
    fdcr_cfg_t cfg_q;
    logic [DATA_W-1:0] status;

    // Decode the port address and qualify the write strobe.
    always_comb begin
        addr_hit = (io_addr == PORT_ADDR);
        wr_hit   = io_wr && addr_hit;
    end

    // Split the write byte into the configuration fields.
    always_comb begin
        cfg_in.drive     = io_wdata[DRV_LSB +: DRV_W];
        cfg_in.mini      = io_wdata[MINI_BIT];
        cfg_in.dbl_dens  = io_wdata[DENS_BIT];
        cfg_in.auto_wait = io_wdata[AWAIT_BIT];
    end

    // Status: all ones from DRQ, then the top bit masked off by INTRQ.
    always_comb begin
        status = fdc_drq ? '1 : '0;
        if (fdc_intrq) status = status & ~TOP_MASK;
        io_rdata = (io_rd && addr_hit) ? status : '0;
    end

    fdcr_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    fdcr_motor_tmr #(.TMO_TICKS(TMO_TICKS)) u_motor (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_hit),
        .head_wr  (io_wdata[HEAD_BIT]),
        .tick     (tick),
        .head_sel (head_sel)
    );

    fdcr_tick_unit #(.RTC_W(RTC_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .ack  (pend_ack),
        .rtc  (rtc_count),
        .pend (tmr_pend)
    );

    // Drive the separate control outputs from the held configuration.
    always_comb begin
        drive_sel  = cfg_q.drive;
        mini_drive = cfg_q.mini;
        dbl_dens   = cfg_q.dbl_dens;
        auto_wait  = cfg_q.auto_wait;
    end

    // R1
    wdata_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |-> !$isunknown(io_wdata));
    // R9
    intrq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && addr_hit && fdc_intrq) |-> !io_rdata[DATA_W-1]);
    // R9
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && addr_hit) |-> io_rdata == '0);
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!head_sel && !tmr_pend && rtc_count == '0 && drive_sel == '0));
endmodule

// File: tb/tb_fdc_ctrl_reg.sv
module tb_fdc_ctrl_reg;
    localparam int CLK_HALF = 10; // 50 MHz

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       fdc_drq = 1'b0, fdc_intrq = 1'b0, tick = 1'b0, pend_ack = 1'b0;
    logic [1:0] drive_sel;
    logic       mini_drive, head_sel, dbl_dens, auto_wait, tmr_pend;
    logic [7:0] rtc_count;

    int vectors = 0;
    int fails = 0;

    // Reference model state
    int m_drv = 0, m_mini = 0, m_hs = 0, m_dd = 0, m_aw = 0, m_cnt = 0, m_rtc = 0, m_pend = 0;

    fdc_ctrl_reg dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .fdc_drq(fdc_drq), .fdc_intrq(fdc_intrq),
        .tick(tick), .pend_ack(pend_ack), .drive_sel(drive_sel), .mini_drive(mini_drive),
        .head_sel(head_sel), .dbl_dens(dbl_dens), .auto_wait(auto_wait),
        .rtc_count(rtc_count), .tmr_pend(tmr_pend)
    );

    always #(CLK_HALF) clk = ~clk;

    // Behavioural model updated at each rising edge (inputs change only at falling edges).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_drv = 0; m_mini = 0; m_hs = 0; m_dd = 0; m_aw = 0; m_cnt = 0; m_rtc = 0; m_pend = 0;
        end else begin
            if (io_wr && io_addr == 8'h14) begin
                m_drv = io_wdata % 4; m_hs = io_wdata[2]; m_dd = io_wdata[3];
                m_mini = io_wdata[4]; m_aw = io_wdata[7]; m_cnt = 0;
            end else if (tick && m_hs == 1) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == 128) begin m_hs = 0; m_cnt = 0; end
            end
            if (tick) begin m_rtc = (m_rtc + 1) % 256; m_pend = 1; end
            else if (pend_ack) m_pend = 0;
        end
    end

    function automatic int exp_rdata();
        if (!(io_rd && io_addr == 8'h14)) return 0;
        if (!fdc_drq) return 0;
        return fdc_intrq ? 8'h7F : 8'hFF;
    endfunction

    task automatic cmp(input string tag, input int act, input int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model once per cycle, away from the edge.
    task automatic compare_all();
        vectors++;
        cmp("R1 R2 R10 drive_sel", drive_sel, m_drv);
        cmp("R3 mini_drive", mini_drive, m_mini);
        cmp("R4 dbl_dens", dbl_dens, m_dd);
        cmp("R4 auto_wait", auto_wait, m_aw);
        cmp("R5 R6 head_sel", head_sel, m_hs);
        cmp("R7 rtc_count", rtc_count, m_rtc);
        cmp("R8 tmr_pend", tmr_pend, m_pend);
        cmp("R9 io_rdata", io_rdata, exp_rdata());
    endtask

    // One cycle: check current state, then apply new inputs for the next edge.
    task automatic step(input logic [7:0] a, input logic w, input logic [7:0] d,
                        input logic t, input logic ack);
        @(negedge clk);
        compare_all();
        io_addr = a; io_wr = w; io_wdata = d; tick = t; pend_ack = ack;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(8'h14, 1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
    endtask

    initial begin
        // R10: reset state
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        // R2 R3 R4 R5: several control patterns
        step(8'h14, 1'b1, 8'h9B, 1'b0, 1'b0); idle(1);
        step(8'h14, 1'b1, 8'h16, 1'b0, 1'b0); idle(1);
        step(8'h14, 1'b1, 8'h61, 1'b0, 1'b0); idle(1);   // R4: bits 5,6 no effect
        // R1: writes to neighbouring addresses ignored
        step(8'h15, 1'b1, 8'hFF, 1'b0, 1'b0); idle(1);
        step(8'h13, 1'b1, 8'hFF, 1'b0, 1'b0); idle(1);
        // R9: status under all DRQ/INTRQ combinations, addressed and not
        io_rd = 1'b1;
        for (int k = 0; k < 4; k++) begin
            fdc_drq = k[0]; fdc_intrq = k[1]; idle(1);
            io_addr = 8'h04; idle(1);
        end
        io_rd = 1'b0;
        // R6: 127 ticks keep the head, the 128th drops it
        step(8'h14, 1'b1, 8'h04, 1'b0, 1'b0);
        ticks(127); idle(2); ticks(1); idle(2);
        // R6: ticks with head clear do not advance the timer
        ticks(50);
        step(8'h14, 1'b1, 8'h04, 1'b0, 1'b0); ticks(100);
        // R5: rewrite restarts the interval; write with tick in same cycle
        step(8'h14, 1'b1, 8'h04, 1'b1, 1'b0); ticks(100); idle(1); ticks(30); idle(2);
        // R8: acknowledge clears; tick with acknowledge keeps it set
        step(8'h00, 1'b0, 8'h00, 1'b0, 1'b1); idle(2);
        step(8'h00, 1'b0, 8'h00, 1'b1, 1'b1); idle(2);
        step(8'h00, 1'b0, 8'h00, 1'b0, 1'b1); idle(1);
        // R7: run past the 8-bit wrap
        ticks(260); idle(2);
        // R10: reset mid-run
        step(8'h14, 1'b1, 8'hFF, 1'b1, 1'b0);
        @(negedge clk); rst_n = 1'b0; idle(2);
        @(negedge clk); rst_n = 1'b1; idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(2 * CLK_HALF * 200000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule